// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, within the same cycle, whether a physical memory access may go ahead. It holds a parameterised set of protection entries. Each entry pairs an 8-bit configuration byte with an address register that stores a word address (the byte address shifted right by two). An access is described by its byte address, its class (instruction fetch, load, or store/AMO) and the privilege level it runs at. The block returns an allow flag and, when the access is refused, a cause code that depends on the access class.

Entries are written through a simple write port with separate enables for the configuration byte and the address register. A read port returns the stored values. A configuration write is made legal before it is stored: reserved bits are cleared, and the reserved permission pair "write without read" cannot be kept. A locked entry keeps its contents until reset, and it also binds machine mode. Each entry can be off, or it can match a top-of-range span, a single 4-byte word, or a naturally aligned power-of-two region. The size of that region comes from the trailing ones in the address register.

Top module: `pmp_checker`

## Requirements
- R1: The configuration byte holds R at bit 0, W at bit 1, X at bit 2, the match mode at bits 4:3 (0 off, 1 top-of-range, 2 aligned 4-byte, 3 power-of-two) and lock at bit 7. Bits 6:5 always read 0. A write to an unlocked entry takes effect at the next rising clock edge, and the read port returns the stored byte.
- R2: A configuration write with W=1 and R=0 is stored with W cleared. No entry ever holds W=1 with R=0.
- R3: Writes to the configuration byte or to the address register of a locked entry (bit 7 = 1) have no effect.
- R4: In aligned 4-byte mode, an entry matches when access address bits [ADDR_W-1:2] equal its address register.
- R5: In power-of-two mode, an address register with t trailing ones describes a naturally aligned region of 2^(t+3) bytes. A register with no trailing ones gives an 8-byte region.
- R6: In power-of-two mode, an all-ones address register matches no address.
- R7: In top-of-range mode, entry i matches when prev <= address[ADDR_W-1:2] < addr_reg[i]. Here prev is the address register of entry i-1, or 0 for entry 0.
- R8: When several entries match, the lowest-numbered one alone decides the result.
- R9: Access class codes are 0 fetch, 1 load, 2 and 3 store/AMO. A matched entry allows the access only if it has X, R or W for that class. cause_o is 0 on allow, and on denial it is 1 for a fetch, 2 for a load and 3 for a store.
- R10: Privilege codes are 0 user, 1 supervisor and 3 machine. Machine mode is allowed when nothing matches or when the deciding entry is unlocked. If the deciding entry is locked, its permissions apply in machine mode too. Any other level with no match is denied.
- R11: After reset, every configuration byte and address register is 0.
- R12: A lookup made in the same cycle as a write uses the contents from before the write. The new contents apply from the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_cfg_en_i | input | 1 | Write enable for a configuration byte |
| wr_addr_en_i | input | 1 | Write enable for an address register |
| wr_idx_i | input | $clog2(N_ENTRIES) | Entry targeted by the write |
| wr_cfg_i | input | 8 | Configuration byte to write |
| wr_addr_i | input | ADDR_W-2 | Word address to write |
| rd_idx_i | input | $clog2(N_ENTRIES) | Entry shown on the read port |
| rd_cfg_o | output | 8 | Stored configuration byte |
| rd_addr_o | output | ADDR_W-2 | Stored address register |
| chk_addr_i | input | ADDR_W | Byte address of the access |
| chk_acc_i | input | 2 | Access class |
| chk_priv_i | input | 2 | Privilege level of the access |
| allow_o | output | 1 | Access permitted |
| cause_o | output | 2 | Denial cause, 0 when allowed |

## Verification
A configuration write and a lookup against that same entry can fall in one cycle. The bench provokes this by driving a write that switches off an 8-byte power-of-two entry while it looks up an address inside that entry. The result is sampled twice. Before the edge the access must still be allowed by the old entry. After the edge the same lookup must fall through to the next, execute-only entry and be denied with the load cause. Priority is judged in a similar way: a read-only word entry overlaps a full-permission region, and a store to that word must be denied.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam int CFG_R    = 0;
  localparam int CFG_W    = 1;
  localparam int CFG_X    = 2;
  localparam int CFG_MODE = 3;
  localparam int CFG_LOCK = 7;

  localparam logic [1:0] MODE_OFF   = 2'd0;
  localparam logic [1:0] MODE_TOR   = 2'd1;
  localparam logic [1:0] MODE_NA4   = 2'd2;
  localparam logic [1:0] MODE_NAPOT = 2'd3;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;

  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [1:0] CAUSE_NONE  = 2'd0;
  localparam logic [1:0] CAUSE_FETCH = 2'd1;
  localparam logic [1:0] CAUSE_LOAD  = 2'd2;
  localparam logic [1:0] CAUSE_STORE = 2'd3;

  // clear reserved bits and drop W when R is clear
  function automatic logic [7:0] cfg_legalize(input logic [7:0] raw);
    logic [7:0] c;
    c = raw;
    c[6:5] = 2'b00;
    c[CFG_W] = raw[CFG_W] & raw[CFG_R];
    return c;
  endfunction
endpackage

// File: rtl/pmp_regs.sv
module pmp_regs #(
  parameter int N_ENTRIES = 4,
  parameter int AR_W      = 30,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_cfg_en_i,
  input  logic                            wr_addr_en_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [7:0]                      wr_cfg_i,
  input  logic [AR_W-1:0]                 wr_addr_i,
  output logic [N_ENTRIES-1:0][7:0]       cfg_o,
  output logic [N_ENTRIES-1:0][AR_W-1:0]  addr_o
);
  import pmp_pkg::*;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel = (wr_idx_i == IDX_W'(i)) && !cfg_o[i][CFG_LOCK];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[i]  <= '0;
        addr_o[i] <= '0;
      end else begin
        if (wr_cfg_en_i && sel)  cfg_o[i]  <= cfg_legalize(wr_cfg_i);
        if (wr_addr_en_i && sel) addr_o[i] <= wr_addr_i;
      end
    end
  end
endmodule

// File: rtl/pmp_entry_match.sv
module pmp_entry_match #(
  parameter int AR_W = 30
) (
  input  logic [1:0]      mode_i,
  input  logic [AR_W-1:0] addr_reg_i,
  input  logic [AR_W-1:0] prev_reg_i,
  input  logic [AR_W-1:0] word_i,
  output logic            hit_o
);
  import pmp_pkg::*;

  logic [AR_W-1:0] napot_mask;
  logic            all_ones;

  // ones over the trailing-one run plus the bit above it
  assign napot_mask = addr_reg_i ^ (addr_reg_i + AR_W'(1));
  assign all_ones   = &addr_reg_i;

  always_comb begin
    unique case (mode_i)
      MODE_TOR:   hit_o = (word_i >= prev_reg_i) && (word_i < addr_reg_i);
      MODE_NA4:   hit_o = (word_i == addr_reg_i);
      MODE_NAPOT: hit_o = !all_ones &&
                          ((word_i & ~napot_mask) == (addr_reg_i & ~napot_mask));
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmp_decide.sv
module pmp_decide #(
  parameter int N_ENTRIES = 4
) (
  input  logic [N_ENTRIES-1:0]      hit_i,
  input  logic [N_ENTRIES-1:0][7:0] cfg_i,
  input  logic [1:0]                acc_i,
  input  logic [1:0]                priv_i,
  output logic                      allow_o,
  output logic [1:0]                cause_o
);
  import pmp_pkg::*;

  logic       found;
  logic [7:0] sel_cfg;
  logic       perm;

  always_comb begin
    found   = 1'b0;
    sel_cfg = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        found   = 1'b1;
        sel_cfg = cfg_i[i];
      end
    end
  end

  always_comb begin
    unique case (acc_i)
      ACC_FETCH: perm = sel_cfg[CFG_X];
      ACC_LOAD:  perm = sel_cfg[CFG_R];
      default:   perm = sel_cfg[CFG_W];
    endcase

    if (priv_i == PRIV_M && (!found || !sel_cfg[CFG_LOCK])) allow_o = 1'b1;
    else if (!found)                                          allow_o = 1'b0;
    else                                                      allow_o = perm;

    if (allow_o)                cause_o = CAUSE_NONE;
    else if (acc_i == ACC_FETCH) cause_o = CAUSE_FETCH;
    else if (acc_i == ACC_LOAD)  cause_o = CAUSE_LOAD;
    else                         cause_o = CAUSE_STORE;
  end
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker #(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int AR_W     = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cfg_en_i,
  input  logic              wr_addr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [7:0]        wr_cfg_i,
  input  logic [AR_W-1:0]   wr_addr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [7:0]        rd_cfg_o,
  output logic [AR_W-1:0]   rd_addr_o,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  logic [1:0]        chk_acc_i,
  input  logic [1:0]        chk_priv_i,
  output logic              allow_o,
  output logic [1:0]        cause_o
);
  import pmp_pkg::*;

  logic [N_ENTRIES-1:0][7:0]      cfg_q;
  logic [N_ENTRIES-1:0][AR_W-1:0] addr_q;
  logic [N_ENTRIES-1:0]           hit;
  logic [AR_W-1:0]                word;
  logic                           unused_lsb;

  assign word       = chk_addr_i[ADDR_W-1:2];
  assign unused_lsb = ^chk_addr_i[1:0];

  pmp_regs #(.N_ENTRIES(N_ENTRIES), .AR_W(AR_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_cfg_en_i  (wr_cfg_en_i),
    .wr_addr_en_i (wr_addr_en_i),
    .wr_idx_i     (wr_idx_i),
    .wr_cfg_i     (wr_cfg_i),
    .wr_addr_i    (wr_addr_i),
    .cfg_o        (cfg_q),
    .addr_o       (addr_q)
  );

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_match
    logic [AR_W-1:0] prev;
    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_rest
      assign prev = addr_q[i-1];
    end

    pmp_entry_match #(.AR_W(AR_W)) u_match (
      .mode_i     (cfg_q[i][CFG_MODE+1:CFG_MODE]),
      .addr_reg_i (addr_q[i]),
      .prev_reg_i (prev),
      .word_i     (word),
      .hit_o      (hit[i])
    );
  end

  pmp_decide #(.N_ENTRIES(N_ENTRIES)) u_decide (
    .hit_i   (hit),
    .cfg_i   (cfg_q),
    .acc_i   (chk_acc_i),
    .priv_i  (chk_priv_i),
    .allow_o (allow_o),
    .cause_o (cause_o)
  );

  assign rd_cfg_o  = cfg_q[rd_idx_i];
  assign rd_addr_o = addr_q[rd_idx_i];
endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva #(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int AR_W     = ADDR_W - 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           wr_cfg_en_i,
  input logic                           wr_addr_en_i,
  input logic [IDX_W-1:0]               wr_idx_i,
  input logic [7:0]                     wr_cfg_i,
  input logic [1:0]                     chk_acc_i,
  input logic                           allow_o,
  input logic [1:0]                     cause_o,
  input logic [N_ENTRIES-1:0][7:0]      cfg_q,
  input logic [N_ENTRIES-1:0][AR_W-1:0] addr_q
);
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    assert_no_w_without_r_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cfg_q[i][1] && !cfg_q[i][0]));
  end

  assert_locked_cfg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg_en_i && cfg_q[wr_idx_i][7]) |=> cfg_q[$past(wr_idx_i)] == $past(cfg_q[wr_idx_i]));

  assert_locked_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_addr_en_i && cfg_q[wr_idx_i][7]) |=> addr_q[$past(wr_idx_i)] == $past(addr_q[wr_idx_i]));

  assert_cfg_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg_en_i && !cfg_q[wr_idx_i][7]) |=>
      (cfg_q[$past(wr_idx_i)][7] == $past(wr_cfg_i[7])) &&
      (cfg_q[$past(wr_idx_i)][4:2] == $past(wr_cfg_i[4:2])) &&
      (cfg_q[$past(wr_idx_i)][0] == $past(wr_cfg_i[0])) &&
      (cfg_q[$past(wr_idx_i)][6:5] == 2'b00));

  assert_allow_no_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allow_o |-> cause_o == 2'd0);

  assert_deny_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !allow_o |-> cause_o == ((chk_acc_i == 2'd0) ? 2'd1 : (chk_acc_i == 2'd1) ? 2'd2 : 2'd3));
endmodule

bind pmp_checker pmp_checker_sva #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_cfg_en_i  (wr_cfg_en_i),
  .wr_addr_en_i (wr_addr_en_i),
  .wr_idx_i     (wr_idx_i),
  .wr_cfg_i     (wr_cfg_i),
  .chk_acc_i    (chk_acc_i),
  .allow_o      (allow_o),
  .cause_o      (cause_o),
  .cfg_q        (cfg_q),
  .addr_q       (addr_q)
);

// File: tb/pmp_checker_tb.sv
module pmp_checker_tb;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int NV = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_cfg_en = 1'b0, wr_addr_en = 1'b0;
  logic [1:0]    wr_idx = '0, rd_idx = '0;
  logic [7:0]    wr_cfg = '0;
  logic [AW-3:0] wr_addr = '0;
  logic [7:0]    rd_cfg;
  logic [AW-3:0] rd_addr;
  logic [AW-1:0] chk_addr = '0;
  logic [1:0]    chk_acc = '0, chk_priv = '0;
  logic          allow;
  logic [1:0]    cause;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmp_checker #(.N_ENTRIES(N), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_cfg_en_i(wr_cfg_en), .wr_addr_en_i(wr_addr_en), .wr_idx_i(wr_idx),
    .wr_cfg_i(wr_cfg), .wr_addr_i(wr_addr),
    .rd_idx_i(rd_idx), .rd_cfg_o(rd_cfg), .rd_addr_o(rd_addr),
    .chk_addr_i(chk_addr), .chk_acc_i(chk_acc), .chk_priv_i(chk_priv),
    .allow_o(allow), .cause_o(cause)
  );

  // {priv, acc, addr, exp_allow, exp_cause}
  localparam logic [38:0] VEC [NV] = '{
    {2'd0, 2'd1, 32'h0000_1000, 1'b1, 2'd0},  // R4 read-only word
    {2'd0, 2'd2, 32'h0000_1000, 1'b0, 2'd3},  // R8 word entry wins over region
    {2'd0, 2'd0, 32'h0000_1003, 1'b0, 2'd1},  // R4/R9 fetch denied
    {2'd0, 2'd2, 32'h0000_1004, 1'b1, 2'd0},  // R5 4 KiB region
    {2'd0, 2'd0, 32'h0000_1FFC, 1'b1, 2'd0},  // R5 region top
    {2'd0, 2'd1, 32'h0000_2000, 1'b0, 2'd2},  // R7 range, exec only
    {2'd0, 2'd0, 32'h0000_2FFF, 1'b1, 2'd0},  // R7 range end
    {2'd0, 2'd1, 32'h0000_3000, 1'b0, 2'd2},  // R7/R10 past range, no match
    {2'd3, 2'd1, 32'h0000_3000, 1'b1, 2'd0},  // R10 machine no match
    {2'd3, 2'd2, 32'h0000_2000, 1'b0, 2'd3},  // R10 locked binds machine
    {2'd3, 2'd2, 32'h0000_1000, 1'b1, 2'd0},  // R10 unlocked machine
    {2'd1, 2'd0, 32'h0000_0FFC, 1'b0, 2'd1},  // R10 supervisor no match
    {2'd1, 2'd3, 32'h0FFF_FFFC, 1'b0, 2'd3},  // R9 class 3 as store
    {2'd0, 2'd1, 32'h0000_0FFC, 1'b0, 2'd2}   // R10 user no match
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_cfg(input logic [1:0] idx, input logic [7:0] val);
    @(negedge clk);
    wr_cfg_en = 1'b1; wr_idx = idx; wr_cfg = val;
    @(negedge clk);
    wr_cfg_en = 1'b0;
  endtask

  task automatic do_addr(input logic [1:0] idx, input logic [AW-3:0] val);
    @(negedge clk);
    wr_addr_en = 1'b1; wr_idx = idx; wr_addr = val;
    @(negedge clk);
    wr_addr_en = 1'b0;
  endtask

  task automatic look(input logic [1:0] priv, input logic [1:0] acc, input logic [31:0] a,
                      input logic ea, input logic [1:0] ec, input string req);
    chk_priv = priv; chk_acc = acc; chk_addr = a;
    #1;
    check(req, {29'd0, allow, cause}, {29'd0, ea, ec});
  endtask

  task automatic read_cfg(input logic [1:0] idx, input logic [7:0] exp, input string req);
    rd_idx = idx;
    #1;
    check(req, {24'd0, rd_cfg}, {24'd0, exp});
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #20 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    for (int i = 0; i < N; i++) read_cfg(2'(i), 8'h00, "R11");
    rd_idx = 2'd1; #1;
    check("R11", {2'd0, rd_addr}, 32'd0);
    look(2'd0, 2'd1, 32'h0, 1'b0, 2'd2, "R11/R10");
    look(2'd3, 2'd0, 32'h0, 1'b1, 2'd0, "R11/R10");

    // setup
    do_addr(2'd0, 30'h400);  do_cfg(2'd0, 8'h11);   // NA4 R
    do_addr(2'd1, 30'h5FF);  do_cfg(2'd1, 8'h1F);   // NAPOT 4 KiB RWX
    do_addr(2'd2, 30'h800);                          // TOR lower bound
    do_addr(2'd3, 30'hC00);  do_cfg(2'd3, 8'h8C);   // TOR X locked
    read_cfg(2'd1, 8'h1F, "R1");
    read_cfg(2'd3, 8'h8C, "R1");

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      look(VEC[v][38:37], VEC[v][36:35], VEC[v][34:3], VEC[v][2], VEC[v][1:0],
           $sformatf("R9 vec%0d", v));
    end

    // R2 legalisation
    do_cfg(2'd2, 8'h02); read_cfg(2'd2, 8'h00, "R2");
    do_cfg(2'd2, 8'h62); read_cfg(2'd2, 8'h00, "R2/R1");
    do_cfg(2'd2, 8'h03); read_cfg(2'd2, 8'h03, "R1");
    do_cfg(2'd2, 8'h00);

    // R3 lock
    do_cfg(2'd3, 8'h00); read_cfg(2'd3, 8'h8C, "R3");
    do_addr(2'd3, 30'h123);
    rd_idx = 2'd3; #1;
    check("R3", {2'd0, rd_addr}, {2'd0, 30'hC00});
    look(2'd0, 2'd0, 32'h0000_2000, 1'b1, 2'd0, "R3");

    // R5 8-byte region, priority over range
    do_cfg(2'd2, 8'h1B);
    look(2'd0, 2'd1, 32'h0000_2004, 1'b1, 2'd0, "R5");
    look(2'd0, 2'd1, 32'h0000_2008, 1'b0, 2'd2, "R5/R8");
    look(2'd0, 2'd1, 32'h0000_1FFC, 1'b1, 2'd0, "R5");

    // R12 write and lookup in the same cycle
    @(negedge clk);
    wr_cfg_en = 1'b1; wr_idx = 2'd2; wr_cfg = 8'h00;
    look(2'd0, 2'd1, 32'h0000_2004, 1'b1, 2'd0, "R12 before");
    @(posedge clk); #1;
    check("R12 after", {30'd0, allow, cause} , {30'd0, 1'b0, 2'd2});
    @(negedge clk);
    wr_cfg_en = 1'b0;

    // R6 reserved all-ones
    do_addr(2'd2, '1);
    do_cfg(2'd2, 8'h1B);
    look(2'd0, 2'd1, 32'h0000_0010, 1'b0, 2'd2, "R6");
    look(2'd0, 2'd1, 32'hFFFF_FFFC, 1'b0, 2'd2, "R6");

    // R5 widest region
    do_addr(2'd2, 30'h1FFF_FFFF);
    look(2'd0, 2'd1, 32'h0000_0010, 1'b1, 2'd0, "R5 full");
    look(2'd0, 2'd2, 32'hFFFF_FFF0, 1'b1, 2'd0, "R5 full");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule